// File: doc/BRIEF.md
# Transmit Enable and Mode Control

This block is the control register and small sequencer for the transmit side of a 10/100 Ethernet MAC. A simple register-write port loads a control word and a descriptor base address. The control word holds four fields: transmit enable, receive enable, a two-bit loopback select and a full-duplex bit. Guard logic checks every control write against the current state. A write that breaks a mode rule is refused, either fully or in part, and sets a sticky error flag. A status-read strobe clears that flag.

Setting transmit enable moves the sequencer out of idle. It then requests a descriptor fetch from a stand-in DMA handshake. A fetch is acknowledged, and after that a frame is in flight until the transmit path reports success or an excessive-collision abort. If transmit enable is still set, the next descriptor is fetched at the address plus a fixed stride. If transmit enable was cleared, the sequencer stops gracefully and returns to idle only once that frame has ended.

Top module: `tx_mode_ctrl`

## Requirements
- R1: After reset, `ctrl_o` reads 0, `tx_idle_o` is 1, `fetch_req_o` is 0 and `err_o` is 0.
- R2: Control word fields:
  - bit 0 is transmit enable.
  - bit 1 is receive enable.
  - bits 3:2 are the loopback select: 00 normal, 01 internal, 10 external.
  - bit 4 is full duplex.
  - Every other bit of `ctrl_o` always reads 0, whatever was written.
- R3: Once transmit enable is set while an address has been programmed, the sequencer leaves idle on the next cycle. It raises `fetch_req_o` with `fetch_addr_o` equal to the programmed address, and holds both until `fetch_ack_i`.
- R4: A write that sets transmit enable before any descriptor address write is handled as follows: transmit enable stays 0, `err_o` is set, and the sequencer stays idle.
- R5: If transmit enable is cleared while a frame is in flight, the sequencer stays busy until `frame_done_i` or `frame_abort_i`. It then returns to idle without a new fetch.
- R6: Either `frame_done_i` or `frame_abort_i` ends a frame. If transmit enable is still 1 at that point, a new fetch starts at the previous address plus `DESC_STRIDE`.
- R7: A control write with loopback 11 is ignored entirely and sets `err_o`.
- R8: A control write that would give internal loopback (01) together with full duplex is ignored entirely and sets `err_o`.
- R9: The full-duplex bit changes only when three conditions hold: the sequencer is idle, transmit enable is 0, and receive enable is 0. At any other time, a write that tries to change it leaves it unchanged, applies the other fields, and sets `err_o`.
- R10: `err_o` is sticky and `rd_stat_i` clears it. If an illegal write and `rd_stat_i` fall in the same cycle, the flag ends up set.
- R11: `tx_idle_o` is 1 exactly when the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the control word, 1 selects the descriptor address |
| wr_data_i | input | DW | Write data |
| rd_stat_i | input | 1 | Status read strobe; clears the error flag |
| ctrl_o | output | CW | Control word readback |
| err_o | output | 1 | Sticky illegal-write flag |
| tx_idle_o | output | 1 | Sequencer is idle |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_addr_o | output | AW | Descriptor address to fetch |
| fetch_ack_i | input | 1 | Fetch acknowledged |
| frame_done_i | input | 1 | Frame sent successfully |
| frame_abort_i | input | 1 | Frame aborted after excessive collisions |

## Verification
A refused write that gets into the control register shows up in `ctrl_o` at the next clock edge. Loopback 11, internal loopback with full duplex, or a duplex change while busy would each appear there, and `err_o` would be wrong at the same moment. A sequencer in the wrong state shows up one edge later, through `tx_idle_o` and `fetch_req_o`. Cases that would reveal it include a start without an address, a stop that does not wait for the frame to end, or a wrong next-descriptor address on `fetch_addr_o`.

// File: rtl/tx_mode_pkg.sv
package tx_mode_pkg;
  typedef enum logic [1:0] {
    LB_NORMAL   = 2'b00,
    LB_INTERNAL = 2'b01,
    LB_EXTERNAL = 2'b10,
    LB_BAD      = 2'b11
  } lb_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_XMIT
  } sq_state_e;

  // bit 4 fd, bits 3:2 loopback, bit 1 rx enable, bit 0 tx enable
  typedef struct packed {
    logic     fd;
    lb_mode_e lb;
    logic     rx_en;
    logic     tx_en;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);
endpackage

// File: rtl/tx_mode_regs.sv
module tx_mode_regs
  import tx_mode_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 32,
  parameter int DESC_STRIDE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_stat_i,
  input  logic          seq_idle_i,
  input  logic          advance_i,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          err_o
);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_STRIDE);

  ctrl_t         ctrl_q, req, nxt;
  logic [AW-1:0] addr_q;
  logic          addr_valid_q, err_q;
  logic          wr_ctrl, wr_addr, fully_idle;
  logic          fd_block, start_block, reject, bad_wr;

  assign wr_ctrl    = wr_en_i && !wr_sel_i;
  assign wr_addr    = wr_en_i && wr_sel_i;
  assign req        = ctrl_t'(wr_data_i[CTRL_BITS-1:0]);
  assign fully_idle = seq_idle_i && !ctrl_q.tx_en && !ctrl_q.rx_en;

  always_comb begin
    fd_block    = (req.fd != ctrl_q.fd) && !fully_idle;
    start_block = req.tx_en && !ctrl_q.tx_en && !addr_valid_q;
    nxt         = req;
    if (fd_block)    nxt.fd    = ctrl_q.fd;
    if (start_block) nxt.tx_en = 1'b0;
    // loopback 11 or internal loopback with full duplex: drop the whole write
    reject = (req.lb == LB_BAD) || (nxt.lb == LB_INTERNAL && nxt.fd);
    bad_wr = wr_ctrl && (reject || fd_block || start_block);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl && !reject) begin
      ctrl_q <= nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= '0;
      addr_valid_q <= 1'b0;
    end else if (wr_addr) begin
      addr_q       <= wr_data_i[AW-1:0];
      addr_valid_q <= 1'b1;
    end else if (advance_i) begin
      addr_q <= addr_q + STRIDE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (bad_wr)    err_q <= 1'b1;
    else if (rd_stat_i) err_q <= 1'b0;
  end

  assign ctrl_o     = ctrl_q;
  assign cur_addr_o = addr_q;
  assign err_o      = err_q;

  AST_LB_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.lb != LB_BAD); // R7
  AST_NO_ILB_FD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_q.lb == LB_INTERNAL && ctrl_q.fd)); // R8
  AST_FD_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fully_idle |=> $stable(ctrl_q.fd)); // R9
  AST_START_NEEDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.tx_en |-> addr_valid_q); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !rd_stat_i |=> err_q); // R10
endmodule

// File: rtl/tx_mode_seq.sv
module tx_mode_seq
  import tx_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic fetch_ack_i,
  input  logic frame_done_i,
  input  logic frame_abort_i,
  output logic fetch_req_o,
  output logic idle_o,
  output logic advance_o
);
  sq_state_e state_q, state_d;
  logic      frame_end;

  assign frame_end = frame_done_i || frame_abort_i;

  always_comb begin
    state_d   = state_q;
    advance_o = 1'b0;
    unique case (state_q)
      SQ_IDLE:  if (tx_en_i) state_d = SQ_FETCH;
      SQ_FETCH: if (fetch_ack_i) state_d = SQ_XMIT;
      SQ_XMIT: if (frame_end) begin
        advance_o = 1'b1;
        state_d   = tx_en_i ? SQ_FETCH : SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  assign fetch_req_o = (state_q == SQ_FETCH);
  assign idle_o      = (state_q == SQ_IDLE);

  AST_START_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && tx_en_i |=> fetch_req_o); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_ack_i |=> fetch_req_o); // R3
  AST_STOP_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SQ_XMIT && !frame_end |=> state_q == SQ_XMIT); // R5
  AST_END_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SQ_XMIT && frame_end && tx_en_i |=> fetch_req_o); // R6
endmodule

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl
  import tx_mode_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 32,
  parameter int CW          = 16,
  parameter int DESC_STRIDE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_stat_i,
  output logic [CW-1:0] ctrl_o,
  output logic          err_o,
  output logic          tx_idle_o,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_ack_i,
  input  logic          frame_done_i,
  input  logic          frame_abort_i
);
  localparam int PAD = CW - CTRL_BITS;

  ctrl_t ctrl;
  logic  seq_idle, advance;

  tx_mode_regs #(.DW(DW), .AW(AW), .DESC_STRIDE(DESC_STRIDE)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .rd_stat_i  (rd_stat_i),
    .seq_idle_i (seq_idle),
    .advance_i  (advance),
    .ctrl_o     (ctrl),
    .cur_addr_o (fetch_addr_o),
    .err_o      (err_o)
  );

  tx_mode_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_en_i       (ctrl.tx_en),
    .fetch_ack_i   (fetch_ack_i),
    .frame_done_i  (frame_done_i),
    .frame_abort_i (frame_abort_i),
    .fetch_req_o   (fetch_req_o),
    .idle_o        (seq_idle),
    .advance_o     (advance)
  );

  // reserved positions read as zero
  assign ctrl_o    = {{PAD{1'b0}}, ctrl};
  assign tx_idle_o = seq_idle;

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_ack_i && !(wr_en_i && wr_sel_i) |=> $stable(fetch_addr_o)); // R3
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> !fetch_req_o); // R11
endmodule

// File: tb/sim_tx_mode_ctrl.sv
module sim_tx_mode_ctrl;
  localparam int DW = 32, AW = 32, CW = 16, STRIDE = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_sel = 1'b0, rd_stat = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          ack = 1'b0, done_s = 1'b0, abort_s = 1'b0;
  logic [CW-1:0] ctrl;
  logic          err, idle, req;
  logic [AW-1:0] addr;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  tx_mode_ctrl #(.DW(DW), .AW(AW), .CW(CW), .DESC_STRIDE(STRIDE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_stat_i(rd_stat), .ctrl_o(ctrl), .err_o(err),
    .tx_idle_o(idle), .fetch_req_o(req), .fetch_addr_o(addr),
    .fetch_ack_i(ack), .frame_done_i(done_s), .frame_abort_i(abort_s)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic stat_read;
    @(negedge clk); rd_stat = 1'b1;
    @(negedge clk); rd_stat = 1'b0;
  endtask

  task automatic ack_pulse;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic done_pulse;
    @(negedge clk); done_s = 1'b1;
    @(negedge clk); done_s = 1'b0;
  endtask

  task automatic abort_pulse;
    @(negedge clk); abort_s = 1'b1;
    @(negedge clk); abort_s = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 ctrl", 64'(ctrl), 0);
    check("R1 idle", 64'(idle), 1);
    check("R1 req", 64'(req), 0);
    check("R1 err", 64'(err), 0);
  endtask

  task automatic t_fields;
    wr(1'b0, 32'hFFFF_FFEA); // rx=1, lb=10, reserved bits set
    check("R2 ctrl fields/reserved", 64'(ctrl), 64'h0A);
    check("R2 no err", 64'(err), 0);
    wr(1'b0, 32'h0);
    wr(1'b0, 32'h10);
    check("R9 fd set when fully idle", 64'(ctrl), 64'h10);
    check("R9 no err", 64'(err), 0);
    wr(1'b0, 32'h0);
    check("R2 cleared", 64'(ctrl), 0);
  endtask

  task automatic t_no_addr;
    wr(1'b0, 32'h01);
    check("R4 tx_en held 0", 64'(ctrl), 0);
    check("R4 err", 64'(err), 1);
    wait_cyc(3);
    check("R4 stays idle", 64'(idle), 1);
    check("R4 no req", 64'(req), 0);
    stat_read;
    check("R10 cleared by read", 64'(err), 0);
  endtask

  task automatic t_run;
    wr(1'b1, 32'h0000_1000);
    wr(1'b0, 32'h01);
    check("R3 ctrl tx_en", 64'(ctrl), 64'h01);
    wait_cyc(1);
    check("R3 req", 64'(req), 1);
    check("R3 addr", 64'(addr), 64'h1000);
    check("R11 not idle", 64'(idle), 0);
    wait_cyc(3);
    check("R3 req held", 64'(req), 1);
    check("R3 addr held", 64'(addr), 64'h1000);
    ack_pulse;
    check("R3 req drops after ack", 64'(req), 0);
    done_pulse;
    check("R6 refetch", 64'(req), 1);
    check("R6 next addr", 64'(addr), 64'h1010);
    ack_pulse;
    wr(1'b0, 32'h0);
    wait_cyc(3);
    check("R5 busy after clear", 64'(idle), 0);
    check("R5 no new req", 64'(req), 0);
    abort_pulse;
    check("R5 idle after abort", 64'(idle), 1);
    check("R6 abort ends, no fetch", 64'(req), 0);
    wait_cyc(2);
    check("R5 stays idle", 64'(req), 0);
  endtask

  task automatic t_fd_busy;
    wr(1'b0, 32'h02);
    wr(1'b0, 32'h12);
    check("R9 fd unchanged while rx on", 64'(ctrl), 64'h02);
    check("R9 err", 64'(err), 1);
    stat_read;
    check("R10 cleared", 64'(err), 0);
  endtask

  task automatic t_lb_bad;
    wr(1'b0, 32'h0C);
    check("R7 write ignored", 64'(ctrl), 64'h02);
    check("R7 err", 64'(err), 1);
    stat_read;
  endtask

  task automatic t_ilb_fd;
    wr(1'b0, 32'h0);
    wr(1'b0, 32'h10);
    wr(1'b0, 32'h14);
    check("R8 write ignored", 64'(ctrl), 64'h10);
    check("R8 err", 64'(err), 1);
    stat_read;
    check("R10 cleared again", 64'(err), 0);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h1C; rd_stat = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; rd_stat = 1'b0;
    check("R10 set wins over read", 64'(err), 1);
    check("R7 ctrl kept", 64'(ctrl), 64'h10);
    stat_read;
    check("R10 final clear", 64'(err), 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset;
    t_fields;
    t_no_addr;
    t_run;
    t_fd_busy;
    t_lb_bad;
    t_ilb_fd;
    t_set_wins;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule